// File: doc/BRIEF.md
# Clock Alarm Transition Event Register

This block sits beside a redundant telecom clock synchronizer and watches four alarm levels from it: primary reference lost, secondary reference lost, PLL in holdover and PLL unlocked. Each level first passes through a multi-flop synchronizer. An edge detector then records every transition, in both directions, as a sticky event bit. Each alarm owns two bits of one cause byte. The first bit of the pair marks a change to asserted and the second marks a change to deasserted.

A host reads the block over a byte-wide bus with a read strobe. Reading the cause byte returns every event gathered since the last read and clears them in the same access. An edge that arrives during that read is not lost. A second address returns the live synchronized alarm levels in the upper half of a byte. A third address returns the interrupt line number assigned to the block, or all ones in the low nibble when the function is configured absent. The interrupt output is dedicated to this block and stays high while any cause bit is set.

Top module: `clk_alarm_evreg`

## Requirements
- R1: Alarm index 0 is primary lost, 1 is secondary lost, 2 is holdover and 3 is unlocked. A 0-to-1 change of alarm i sets cause bit 2*i, and a 1-to-0 change sets cause bit 2*i+1.
- R2: A read strobe at address 0 (cause) returns the accumulated cause byte on bus_rdata after that clock edge and clears the cause register in the same edge.
- R3: An edge whose event is produced in the same clock as a clearing read is absent from that read's data and is present in the cause register afterwards.
- R4: irq is high whenever any cause bit is set. It goes low in the cycle after a clearing read that coincides with no new event, and a set cause bit stays set until a clearing read.
- R5: A read at address 1 (status) returns primary lost in bit 7, secondary lost in bit 6, holdover in bit 5 and unlocked in bit 4, with bits 3..0 zero.
- R6: A read at address 2 (line) returns the IRQ_LINE parameter (default 5) in bits 3..0 with bits 7..4 zero. When LINE_PRESENT is 0 the low nibble reads 0xF.
- R7: After reset the cause register is zero and irq is low. Alarm levels held steady through reset produce no events.
- R8: An alarm input change driven before clock edge E0 sets its cause bit and irq at edge E2: two synchronizer stages plus the cause register. Nothing is visible after edge E1.
- R9: A read at any address other than 0, 1 or 2 returns zero and leaves the cause register unchanged.
- R10: Events accumulate between reads: several transitions on different alarms, or a rise followed by a fall on one alarm, all stay set until the next clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_in | input | N_ALARM (4) | Asynchronous alarm levels, index order as in R1 |
| bus_addr | input | ADDR_W (3) | Register address for a read |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W (8) | Read data, registered, valid the cycle after the strobe |
| irq | output | 1 | Dedicated level interrupt, high while any cause bit is set |

## Verification
Corrupt edge-detector history would show up as spurious or missing cause bits on the next cause read. It would also raise irq exactly two edges after an input change instead of three, or raise it with no input change at all. A cause register that mishandles the clear shows up at the first read that overlaps a new edge: the event is either returned early or lost, and the very next read tells which. A wrong bit position in the pair packing or the status byte shows up as a wrong value on the first read after a single alarm toggles, because the bench changes one alarm at a time in its directed cases.

// File: rtl/cae_pkg.sv
package cae_pkg;

   typedef enum int {
      AL_PRI_LOS  = 0,
      AL_SEC_LOS  = 1,
      AL_HOLDOVER = 2,
      AL_UNLOCK   = 3
   } alarm_idx_e;

   // rising event bit for alarm i (lower bit of the pair)
   function automatic int rise_pos(input int i);
      return 2 * i;
   endfunction

   // falling event bit for alarm i (upper bit of the pair)
   function automatic int fall_pos(input int i);
      return 2 * i + 1;
   endfunction

endpackage

// File: rtl/cae_sync.sv
module cae_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cae_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         chain_q <= {chain_q[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/cae_edge_cause.sv
module cae_edge_cause
   import cae_pkg::*;
#(
   parameter int N_ALARM = 4,
   localparam int CW     = 2 * N_ALARM
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_ALARM-1:0] lvl,
   input  logic               clr,
   output logic [CW-1:0]      new_ev,
   output logic [CW-1:0]      cause_q
);

   logic [N_ALARM-1:0] prev_q;
   logic [CW-1:0]      cause_d;

   // history follows the synchronized level in every cycle, reset included,
   // so levels that are steady through reset never look like edges
   always_ff @(posedge clk) begin
      prev_q <= lvl;
   end

   for (genvar i = 0; i < N_ALARM; i++) begin : g_pair
      assign new_ev[rise_pos(i)] =  lvl[i] & ~prev_q[i];
      assign new_ev[fall_pos(i)] = ~lvl[i] &  prev_q[i];
   end

   // clear first, then merge the events of this cycle so none is dropped
   always_comb begin
      cause_d = clr ? '0 : cause_q;
      cause_d = cause_d | new_ev;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else begin
         cause_q <= cause_d;
      end
   end

endmodule

// File: rtl/cae_regread.sv
module cae_regread #(
   parameter int          ADDR_W      = 3,
   parameter int          DATA_W      = 8,
   parameter int          CW          = 8,
   parameter logic [ADDR_W-1:0] ADDR_CAUSE  = 0,
   parameter logic [ADDR_W-1:0] ADDR_STATUS = 1,
   parameter logic [ADDR_W-1:0] ADDR_LINE   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic [CW-1:0]     cause,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] line,
   output logic              clr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] sel_d;
   logic [DATA_W-1:0] cause_ext;

   if (CW > DATA_W) begin : g_bad_cw
      $error("cae_regread: cause width exceeds data width");
   end else if (CW == DATA_W) begin : g_cause_full
      assign cause_ext = cause;
   end else begin : g_cause_pad
      assign cause_ext = {{(DATA_W-CW){1'b0}}, cause};
   end

   assign clr = rd && (addr == ADDR_CAUSE);

   always_comb begin
      unique case (addr)
         ADDR_CAUSE:  sel_d = cause_ext;
         ADDR_STATUS: sel_d = status;
         ADDR_LINE:   sel_d = line;
         default:     sel_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= sel_d;
      end
   end

endmodule

// File: rtl/clk_alarm_evreg.sv
module clk_alarm_evreg #(
   parameter int N_ALARM      = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int ADDR_W       = 3,
   parameter int DATA_W       = 8,
   parameter int IRQ_LINE     = 5,
   parameter bit LINE_PRESENT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_ALARM-1:0] alarm_in,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq
);

   localparam int CW = 2 * N_ALARM;
   localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_LINE   = ADDR_W'(2);

   if (CW > DATA_W) begin : g_chk_width
      $error("clk_alarm_evreg: 2*N_ALARM must fit in DATA_W");
   end
   if (DATA_W < 4 || ADDR_W < 2) begin : g_chk_bus
      $error("clk_alarm_evreg: bus too narrow");
   end
   if (LINE_PRESENT && (IRQ_LINE < 0 || IRQ_LINE > 14)) begin : g_chk_line
      $error("clk_alarm_evreg: IRQ_LINE must be 0..14 when present");
   end

   logic [N_ALARM-1:0] lvl_s;
   logic [CW-1:0]      new_ev;
   logic [CW-1:0]      cause_q;
   logic               clr;
   logic [DATA_W-1:0]  status_b;
   logic [DATA_W-1:0]  line_b;

   cae_sync #(
      .WIDTH  (N_ALARM),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .d_async (alarm_in),
      .q_sync  (lvl_s)
   );

   cae_edge_cause #(
      .N_ALARM (N_ALARM)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl_s),
      .clr     (clr),
      .new_ev  (new_ev),
      .cause_q (cause_q)
   );

   // live levels placed from the top bit downward, alarm 0 highest
   for (genvar i = 0; i < DATA_W; i++) begin : g_status
      if (i >= DATA_W - N_ALARM) begin : g_live
         assign status_b[i] = lvl_s[DATA_W-1-i];
      end else begin : g_zero
         assign status_b[i] = 1'b0;
      end
   end

   if (LINE_PRESENT) begin : g_line_on
      assign line_b = {{(DATA_W-4){1'b0}}, 4'(IRQ_LINE)};
   end else begin : g_line_off
      assign line_b = {{(DATA_W-4){1'b0}}, 4'hF};
   end

   cae_regread #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CW          (CW),
      .ADDR_CAUSE  (A_CAUSE),
      .ADDR_STATUS (A_STATUS),
      .ADDR_LINE   (A_LINE)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .rd     (bus_rd),
      .cause  (cause_q),
      .status (status_b),
      .line   (line_b),
      .clr    (clr),
      .rdata  (bus_rdata)
   );

   assign irq = |cause_q;

endmodule

// File: rtl/cae_chk.sv
module cae_chk #(
   parameter int N_ALARM  = 4,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter int LINE_VAL = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_ALARM-1:0] alarm_in,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_rd,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq,
   input logic [2*N_ALARM-1:0] new_ev,
   input logic [2*N_ALARM-1:0] cause_q
);

   logic rd_cause, rd_status, rd_line;
   assign rd_cause  = bus_rd && (bus_addr == ADDR_W'(0));
   assign rd_status = bus_rd && (bus_addr == ADDR_W'(1));
   assign rd_line   = bus_rd && (bus_addr == ADDR_W'(2));

   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && irq) |=> (bus_rdata != '0)); // R2

   AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && (new_ev != '0)) |=> (cause_q != '0)); // R3

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_cause) |=> irq); // R4

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cause && (new_ev == '0)) |=> !irq); // R4

   AST_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status |=> (bus_rdata[DATA_W-N_ALARM-1:0] == '0)); // R5

   AST_LINE_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_line |=> (bus_rdata == DATA_W'(LINE_VAL))); // R6

   AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(alarm_in, 3) != $past(alarm_in, 4))); // R8

endmodule

bind clk_alarm_evreg cae_chk #(
   .N_ALARM  (N_ALARM),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LINE_VAL (LINE_PRESENT ? IRQ_LINE : 15)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .alarm_in  (alarm_in),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .new_ev    (new_ev),
   .cause_q   (cause_q)
);

// File: tb/sim_clk_alarm_evreg.sv
`timescale 1ns/1ps
module sim_clk_alarm_evreg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] alarm_in = 4'b0101;
   logic [2:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       irq;

   int total = 0;
   int bad   = 0;
   logic [3:0] cur_lvl;
   logic [7:0] exp_cause;

   always #5 clk = ~clk;

   clk_alarm_evreg u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .alarm_in  (alarm_in),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [7:0] edges(input logic [3:0] o, input logic [3:0] n);
      logic [7:0] e = '0;
      for (int i = 0; i < 4; i++) begin
         if (!o[i] && n[i]) e[2*i]   = 1'b1;
         if (o[i] && !n[i]) e[2*i+1] = 1'b1;
      end
      return e;
   endfunction

   function automatic logic [7:0] status_of(input logic [3:0] l);
      return {l[0], l[1], l[2], l[3], 4'b0000};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%02h exp=%02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      tick(1);
      bus_rd   = 1'b0;
      d        = bus_rdata;
   endtask

   task automatic set_lvl(input logic [3:0] v);
      exp_cause = exp_cause | edges(cur_lvl, v);
      cur_lvl   = v;
      alarm_in  = v;
      tick(4);
   endtask

   initial begin
      #2ms;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      cur_lvl   = 4'b0101;
      exp_cause = '0;
      tick(6);
      rst_n = 1'b1;
      tick(5);

      // R7: steady levels through reset make no events
      chk("R7 irq", {7'd0, irq}, 8'h00);
      rd(3'd0, d); chk("R7 cause", d, 8'h00);
      rd(3'd1, d); chk("R5 status", d, status_of(cur_lvl));
      rd(3'd2, d); chk("R6 line", d, 8'h05);
      rd(3'd5, d); chk("R9 unmapped", d, 8'h00);

      // R8: latency, unlock rise
      alarm_in = 4'b1101; cur_lvl = 4'b1101;
      tick(2); chk("R8 early", {7'd0, irq}, 8'h00);
      tick(1); chk("R8 irq", {7'd0, irq}, 8'h01);
      rd(3'd7, d); chk("R9 no clear", {7'd0, irq}, 8'h01);
      rd(3'd0, d); chk("R1 unlock rise", d, 8'h40);
      chk("R4 drop", {7'd0, irq}, 8'h00);

      // R1 individual pairs
      set_lvl(4'b1100); rd(3'd0, d); chk("R1 pri fall", d, 8'h02); exp_cause = '0;
      set_lvl(4'b1110); rd(3'd0, d); chk("R1 sec rise", d, 8'h04); exp_cause = '0;
      set_lvl(4'b1010); rd(3'd0, d); chk("R1 hold fall", d, 8'h20); exp_cause = '0;

      // R10: rise then fall on one alarm accumulate
      set_lvl(4'b1011); set_lvl(4'b1010);
      rd(3'd0, d); chk("R10 accumulate", d, 8'h03); exp_cause = '0;

      // R3: edge arrives during the clearing read
      set_lvl(4'b1110);
      alarm_in = 4'b0110; cur_lvl = 4'b0110;
      tick(2);
      rd(3'd0, d); chk("R3 old only", d, 8'h10);
      chk("R4 stays", {7'd0, irq}, 8'h01);
      rd(3'd0, d); chk("R3 kept", d, 8'h80);
      exp_cause = '0;

      // constrained random walk
      for (int it = 0; it < 250; it++) begin
         set_lvl(4'($urandom() % 16));
         if (($urandom() % 3) != 0) begin
            chk("R4 irq", {7'd0, irq}, {7'd0, |exp_cause});
            rd(3'd0, d); chk("R2 cause", d, exp_cause);
            exp_cause = '0;
            rd(3'd1, d); chk("R5 status", d, status_of(cur_lvl));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule